// File: doc/BRIEF.md
# Interrupt Remapping Index Checker

This block screens remappable interrupt requests before they are delivered. Each request carries an address word, a subhandle data value and the requester's source ID. The address holds a 16-bit handle and a subhandle-valid flag. The block forms the remapping table index from these fields and range-checks it against both the physical table depth and a programmable size limit. It then reads the selected entry from a small on-chip table and, when that entry asks for it, compares the stored source ID with the requester's.

The outcome is one response record per accepted request. A response either carries the translated vector and destination fields, or it carries a fault flag, a reason code and the full computed index. Requests and responses use valid/ready handshakes. A plain register-style write port loads the table entries and the size limit.

Top module: `irq_remap_checker`

## Requirements
- R1: The handle is taken from address bits [20:5], and the subhandle-valid flag from address bit 3. When the flag is set, the index is the 17-bit sum of the handle and the subhandle. When the flag is clear, the index is the handle alone and the subhandle has no effect.
- R2: A sum above 16'hFFFF faults with reason 8'h21, and rsp_index reports the full 17-bit sum. The low 16 bits of such a sum never select an entry. An index of exactly 16'hFFFF is legal.
- R3: An index at or above the smaller of the size register and the parameter ENTRIES faults with reason 8'h21. The size register is 17 bits wide and loads through size_we.
- R4: An index in range that selects an entry whose present bit is clear faults with reason 8'h22.
- R5: If the selected entry has its check-enable bit set and its stored source ID differs from req_sid, the request faults with reason 8'h26. If the check-enable bit is clear, no source-ID comparison is made.
- R6: Exactly one reason is reported per request, in this priority: out of range (8'h21), then not present (8'h22), then source-ID mismatch (8'h26). rsp_fault is 1 exactly when rsp_reason is non-zero.
- R7: A request that passes all checks responds with rsp_fault 0, rsp_reason 0, the index, and the vector and destination stored in the entry.
- R8: Every accepted request produces exactly one response, in order, on the clock edge after acceptance. req_ready is high when no response is held or when rsp_ready is high. A response that is held by rsp_ready low stays unchanged.
- R9: After reset, rsp_valid is 0, req_ready is 1, every entry is not present, and the size register holds ENTRIES.
- R10: A table write (tbl_we with tbl_waddr and its entry fields) takes effect at the clock edge. A request accepted at that same edge sees the entry's previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | ADDR_W | Request address: handle [20:5], subhandle-valid [3] |
| req_subh | input | 16 | Subhandle data value |
| req_sid | input | SID_W | Requester source ID |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_fault | output | 1 | Request faulted |
| rsp_reason | output | 8 | Fault reason code, 0 when translated |
| rsp_index | output | 17 | Computed table index |
| rsp_vector | output | VEC_W | Translated vector |
| rsp_dest | output | DEST_W | Translated destination |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_waddr | input | AW | Entry slot to write |
| tbl_wpresent | input | 1 | Present bit to write |
| tbl_wchk | input | 1 | Source-ID check enable to write |
| tbl_wsid | input | SID_W | Source ID to write |
| tbl_wvec | input | VEC_W | Vector to write |
| tbl_wdest | input | DEST_W | Destination to write |
| size_we | input | 1 | Size register write strobe |
| size_wdata | input | 17 | New size limit |

## Verification
The bench drives handle and subhandle pairs that sum to exactly 16'hFFFF and to 17'h10000. The first must translate. The second must fault with reason 21h; a design that keeps only 16 bits of the sum would instead translate or fault on entry 0. A further pair overflows to an index whose low 16 bits select a present entry with a mismatching source ID. A design that wraps the index, or that ranks the checks wrongly, reports 26h there instead of 21h. Other cases cover the size limit one below and at the programmed value, a write and a lookup of the same entry at the same edge, and a response held under back-pressure while the next request waits.

// File: rtl/irq_remap_checker.sv
module irq_remap_checker #(
  parameter int ENTRIES = 64,
  parameter int ADDR_W  = 32,
  parameter int SID_W   = 16,
  parameter int VEC_W   = 8,
  parameter int DEST_W  = 8,
  localparam int AW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_subh,
  input  logic [SID_W-1:0]  req_sid,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_fault,
  output logic [7:0]        rsp_reason,
  output logic [16:0]       rsp_index,
  output logic [VEC_W-1:0]  rsp_vector,
  output logic [DEST_W-1:0] rsp_dest,
  input  logic              tbl_we,
  input  logic [AW-1:0]     tbl_waddr,
  input  logic              tbl_wpresent,
  input  logic              tbl_wchk,
  input  logic [SID_W-1:0]  tbl_wsid,
  input  logic [VEC_W-1:0]  tbl_wvec,
  input  logic [DEST_W-1:0] tbl_wdest,
  input  logic              size_we,
  input  logic [16:0]       size_wdata
);

  localparam logic [7:0]  RSN_RANGE  = 8'h21;
  localparam logic [7:0]  RSN_ABSENT = 8'h22;
  localparam logic [7:0]  RSN_SID    = 8'h26;
  localparam logic [16:0] ENT_LIM    = 17'(ENTRIES);

  logic [ENTRIES-1:0] present_q;
  logic [ENTRIES-1:0] chk_q;
  logic [SID_W-1:0]   sid_mem  [ENTRIES];
  logic [VEC_W-1:0]   vec_mem  [ENTRIES];
  logic [DEST_W-1:0]  dest_mem [ENTRIES];
  logic [16:0]        size_q;

  wire [15:0] handle = req_addr[20:5];
  wire        shv    = req_addr[3];
  wire [16:0] index  = shv ? ({1'b0, handle} + {1'b0, req_subh}) : {1'b0, handle};
  wire [16:0] limit  = (size_q < ENT_LIM) ? size_q : ENT_LIM;
  wire        out_of_range = (index >= limit);
  wire [AW-1:0] slot = index[AW-1:0];

  wire hit_present = !out_of_range && present_q[slot];
  wire sid_bad     = chk_q[slot] && (sid_mem[slot] != req_sid);

  logic [7:0] reason;
  always_comb begin
    if (out_of_range)      reason = RSN_RANGE;
    else if (!hit_present) reason = RSN_ABSENT;
    else if (sid_bad)      reason = RSN_SID;
    else                   reason = 8'h00;
  end

  assign req_ready = !rsp_valid || rsp_ready;
  wire accept = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      present_q <= '0;
      chk_q     <= '0;
      size_q    <= ENT_LIM;
    end else begin
      if (tbl_we) begin
        present_q[tbl_waddr] <= tbl_wpresent;
        chk_q[tbl_waddr]     <= tbl_wchk;
      end
      if (size_we) size_q <= size_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (tbl_we) begin
      sid_mem[tbl_waddr]  <= tbl_wsid;
      vec_mem[tbl_waddr]  <= tbl_wvec;
      dest_mem[tbl_waddr] <= tbl_wdest;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_reason <= '0;
      rsp_index  <= '0;
      rsp_vector <= '0;
      rsp_dest   <= '0;
    end else if (accept) begin
      rsp_valid  <= 1'b1;
      rsp_fault  <= (reason != 8'h00);
      rsp_reason <= reason;
      rsp_index  <= index;
      rsp_vector <= (reason == 8'h00) ? vec_mem[slot]  : '0;
      rsp_dest   <= (reason == 8'h00) ? dest_mem[slot] : '0;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_reason) && $stable(rsp_index) && $stable(rsp_vector)); // R8

  AST_RSP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && req_ready)); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_addr[3] && (({1'b0, req_addr[20:5]} + {1'b0, req_subh}) > 17'h0FFFF))
    |=> rsp_valid && rsp_fault && rsp_reason == 8'h21); // R2

  AST_PASS_IN_16: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_index[16] == 1'b0); // R2

  AST_ONE_REASON: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault == (rsp_reason != 8'h00)) &&
      (rsp_reason == 8'h00 || rsp_reason == 8'h21 || rsp_reason == 8'h22 || rsp_reason == 8'h26)); // R6

  AST_HANDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_addr[3] |=> rsp_index == $past({1'b0, req_addr[20:5]})); // R1

endmodule

// File: tb/irq_remap_checker_tb.sv
module irq_remap_checker_tb_top;
  localparam int ENT = 65536;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 0, rsp_ready = 1;
  logic [31:0] req_addr = 0;
  logic [15:0] req_subh = 0, req_sid = 0;
  logic        req_ready, rsp_valid, rsp_fault;
  logic [7:0]  rsp_reason, rsp_vector, rsp_dest;
  logic [16:0] rsp_index;
  logic        tbl_we = 0, tbl_wpresent = 0, tbl_wchk = 0, size_we = 0;
  logic [15:0] tbl_waddr = 0, tbl_wsid = 0;
  logic [7:0]  tbl_wvec = 0, tbl_wdest = 0;
  logic [16:0] size_wdata = 0;

  irq_remap_checker #(.ENTRIES(ENT)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_subh(req_subh), .req_sid(req_sid),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
    .rsp_reason(rsp_reason), .rsp_index(rsp_index), .rsp_vector(rsp_vector), .rsp_dest(rsp_dest),
    .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wpresent(tbl_wpresent), .tbl_wchk(tbl_wchk),
    .tbl_wsid(tbl_wsid), .tbl_wvec(tbl_wvec), .tbl_wdest(tbl_wdest),
    .size_we(size_we), .size_wdata(size_wdata)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  task automatic wr_entry(input logic [15:0] a, input logic p, input logic c,
                          input logic [15:0] s, input logic [7:0] v, input logic [7:0] d);
    @(negedge clk);
    tbl_we = 1; tbl_waddr = a; tbl_wpresent = p; tbl_wchk = c;
    tbl_wsid = s; tbl_wvec = v; tbl_wdest = d;
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic wr_size(input logic [16:0] sz);
    @(negedge clk);
    size_we = 1; size_wdata = sz;
    @(negedge clk);
    size_we = 0;
  endtask

  task automatic drive(input logic shv, input logic [15:0] h, input logic [15:0] s, input logic [15:0] sid);
    req_addr = 32'h0; req_addr[20:5] = h; req_addr[3] = shv;
    req_subh = s; req_sid = sid; req_valid = 1;
  endtask

  // one request at a negedge, response sampled at the following negedge
  task automatic send(input logic shv, input logic [15:0] h, input logic [15:0] s, input logic [15:0] sid);
    @(negedge clk);
    drive(shv, h, s, sid);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic expect_rsp(input string tag, input logic f, input logic [7:0] r,
                            input logic [16:0] idx, input logic [7:0] v, input logic [7:0] d);
    chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " fault"}, 32'(rsp_fault), 32'(f));
    chk({tag, " reason"}, 32'(rsp_reason), 32'(r));
    chk({tag, " index"}, 32'(rsp_index), 32'(idx));
    if (!f) begin
      chk({tag, " vector"}, 32'(rsp_vector), 32'(v));
      chk({tag, " dest"}, 32'(rsp_dest), 32'(d));
    end
  endtask

  typedef struct packed {
    logic        shv;
    logic [15:0] h;
    logic [15:0] s;
    logic [15:0] sid;
    logic        flt;
    logic [7:0]  rsn;
    logic [16:0] idx;
    logic [7:0]  vec;
    logic [7:0]  dst;
  } tv_t;

  localparam int NV = 11;
  localparam tv_t VECS [NV] = '{
    '{1'b1, 16'h0003, 16'h0002, 16'h1234, 1'b0, 8'h00, 17'h00005, 8'h41, 8'h02}, // R1 R7 sum path
    '{1'b0, 16'h0005, 16'h7777, 16'h1234, 1'b0, 8'h00, 17'h00005, 8'h41, 8'h02}, // R1 subhandle ignored
    '{1'b1, 16'hFF00, 16'h00FF, 16'h0000, 1'b0, 8'h00, 17'h0FFFF, 8'h7E, 8'hA0}, // R2 exactly FFFF
    '{1'b1, 16'hFF00, 16'h0100, 16'h0000, 1'b1, 8'h21, 17'h10000, 8'h00, 8'h00}, // R2 exactly 10000
    '{1'b1, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b1, 8'h21, 17'h1FFFE, 8'h00, 8'h00}, // R2 largest sum
    '{1'b0, 16'h0010, 16'h0000, 16'h0000, 1'b1, 8'h22, 17'h00010, 8'h00, 8'h00}, // R4 absent
    '{1'b1, 16'h0004, 16'h0001, 16'h9999, 1'b1, 8'h26, 17'h00005, 8'h00, 8'h00}, // R5 mismatch
    '{1'b0, 16'h0020, 16'h0000, 16'hBEEF, 1'b0, 8'h00, 17'h00020, 8'h55, 8'h33}, // R5 match
    '{1'b0, 16'h0020, 16'h0000, 16'hBEEE, 1'b1, 8'h26, 17'h00020, 8'h00, 8'h00}, // R5 one bit off
    '{1'b0, 16'hFFFF, 16'h0000, 16'h4321, 1'b0, 8'h00, 17'h0FFFF, 8'h7E, 8'hA0}, // R5 check disabled
    '{1'b1, 16'hFFF0, 16'h0015, 16'h9999, 1'b1, 8'h21, 17'h10005, 8'h00, 8'h00}  // R6 range beats sid
  };

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk("R9 req_ready after reset", 32'(req_ready), 32'd1);
    @(negedge clk);
    rst_n = 1;
    send(1'b0, 16'h0005, 16'h0, 16'h0);
    expect_rsp("R9 entry absent after reset", 1'b1, 8'h22, 17'h00005, 8'h0, 8'h0);
    send(1'b0, 16'hFFFF, 16'h0, 16'h0);
    expect_rsp("R9 size resets to ENTRIES", 1'b1, 8'h22, 17'h0FFFF, 8'h0, 8'h0);

    wr_entry(16'h0005, 1'b1, 1'b1, 16'h1234, 8'h41, 8'h02);
    wr_entry(16'hFFFF, 1'b1, 1'b0, 16'h0000, 8'h7E, 8'hA0);
    wr_entry(16'h0020, 1'b1, 1'b1, 16'hBEEF, 8'h55, 8'h33);

    foreach (VECS[i]) begin
      send(VECS[i].shv, VECS[i].h, VECS[i].s, VECS[i].sid);
      expect_rsp($sformatf("table vector %0d", i), VECS[i].flt, VECS[i].rsn,
                 VECS[i].idx, VECS[i].vec, VECS[i].dst);
    end

    // R3 programmed size limit
    wr_size(17'h00020);
    send(1'b0, 16'h0020, 16'h0, 16'hBEEF);
    expect_rsp("R3 index equals size", 1'b1, 8'h21, 17'h00020, 8'h0, 8'h0);
    send(1'b0, 16'h001F, 16'h0, 16'h0);
    expect_rsp("R3 index size-1 in range", 1'b1, 8'h22, 17'h0001F, 8'h0, 8'h0);
    send(1'b1, 16'h0001, 16'h0004, 16'h1234);
    expect_rsp("R3 small index passes", 1'b0, 8'h00, 17'h00005, 8'h41, 8'h02);
    wr_size(17'h10000);

    // R10 write and lookup at the same edge
    @(negedge clk);
    tbl_we = 1; tbl_waddr = 16'h0030; tbl_wpresent = 1; tbl_wchk = 0;
    tbl_wsid = 0; tbl_wvec = 8'h99; tbl_wdest = 8'h11;
    drive(1'b0, 16'h0030, 16'h0, 16'h0);
    @(negedge clk);
    tbl_we = 0; req_valid = 0;
    expect_rsp("R10 same-edge sees old entry", 1'b1, 8'h22, 17'h00030, 8'h0, 8'h0);
    send(1'b0, 16'h0030, 16'h0, 16'h0);
    expect_rsp("R10 later sees new entry", 1'b0, 8'h00, 17'h00030, 8'h99, 8'h11);

    // R8 back-pressure: hold A, queue B, release
    @(negedge clk);
    rsp_ready = 0;
    drive(1'b0, 16'h0005, 16'h0, 16'h1234);
    @(negedge clk);
    chk("R8 req_ready low while held", 32'(req_ready), 32'd0);
    drive(1'b0, 16'hFFFF, 16'h0, 16'h0);
    @(negedge clk);
    expect_rsp("R8 held response A", 1'b0, 8'h00, 17'h00005, 8'h41, 8'h02);
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    expect_rsp("R8 next response B", 1'b0, 8'h00, 17'h0FFFF, 8'h7E, 8'hA0);
    @(negedge clk);
    chk("R8 single response per request", 32'(rsp_valid), 32'd0);

    summary();
  end
endmodule